// File: doc/BRIEF.md
# Serial Transceiver with Selectable Loopback Paths

This block pairs an asynchronous serial transmitter with a receiver that feeds an eight-entry receive FIFO. Software-facing logic hands it bytes through a one-deep holding register and pulls received bytes from the FIFO head. Two control inputs reroute the serial paths. In system loopback the receiver listens to the transmitter's own serial output. In line loopback the outgoing pin repeats whatever arrives on the incoming pin.

The receiver treats any low level on its selected input as a start bit, as long as it is idle and enabled. Changing the input source while the line is low can therefore create a phantom byte. The safe sequence is to disable the receiver or keep its input high, let at least ten bit times pass, and then pulse the flush input. The flush empties the FIFO and clears the sticky error flags.

Top module: `uart_lb_top`

## Requirements
- R1: With `sys_loop_i` high, the receiver input comes from the transmit serializer, two clocks later through the synchronizer, and `rxd_i` has no effect on received data.
- R2: With `line_loop_i` high, `txd_o` equals `rxd_i` in the same cycle, including while the serializer is mid-frame.
- R3: `rx_level_o` counts the bytes held in the FIFO, is 0 after reset and never exceeds 8.
- R4: While idle and enabled, the receiver takes a low input as a start candidate. It commits to a frame only if the input is still low at mid start bit, so a pulse shorter than half a bit yields no byte. A line held low from idle yields a byte of 0x00.
- R5: With `rx_en_i` low, or with the selected input constantly high, no byte enters the FIFO.
- R6: A frame is a start bit of 0, eight data bits sent least significant bit first, and a stop bit of 1. Each bit lasts OSR (16) sample ticks of DIV clocks each, which is 64 clocks by default. The line idles at 1.
- R7: A one-cycle `flush_i` pulse sets the level to 0 and clears `frame_err_o` and `overflow_o`.
- R8: `rx_data_o` shows the oldest byte while `rx_valid_o` is high, and `rx_pop_i` removes it, so bytes leave in arrival order.
- R9: A stop bit sampled low sets the sticky `frame_err_o`, and the byte is still stored.
- R10: A byte that arrives while the FIFO holds 8 entries is dropped and sets the sticky `overflow_o`. The stored entries are unchanged.
- R11: `tx_ready_o` is low while the holding register is occupied. A new frame begins only after the previous stop bit has finished, so two bytes written back to back arrive intact and in order.
- R12: After reset, `txd_o` is 1, `tx_ready_o` is 1, and `rx_valid_o`, `frame_err_o` and `overflow_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sys_loop_i | input | 1 | Receiver listens to the transmit serializer |
| line_loop_i | input | 1 | Outgoing pin repeats the incoming pin |
| rx_en_i | input | 1 | Receiver enable |
| flush_i | input | 1 | Empty the FIFO and clear the sticky flags |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | Write strobe for `tx_data_i` |
| tx_ready_o | output | 1 | Holding register is free |
| rx_data_o | output | 8 | Oldest received byte |
| rx_valid_o | output | 1 | FIFO is not empty |
| rx_pop_i | input | 1 | Remove the oldest byte |
| rx_level_o | output | 4 | Number of bytes in the FIFO |
| frame_err_o | output | 1 | Sticky: a stop bit was sampled low |
| overflow_o | output | 1 | Sticky: a byte was dropped on a full FIFO |
| rxd_i | input | 1 | Serial input pin |
| txd_o | output | 1 | Serial output pin |

## Verification
A wrong receiver state shows up at `rx_level_o` about one frame later, at the mid stop-bit sample. It appears either as a missing byte or as a phantom byte of 0x00 with `frame_err_o` set. A mis-sequenced transmitter shows as shifted or merged bytes when the data is read back through system loopback, roughly ten bit times after the write. FIFO pointer or count faults show immediately at `rx_level_o` and in the order of bytes returned by pops. A broken line echo is visible on `txd_o` in the same cycle that `rxd_i` changes.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } ser_state_e;

  // next occupancy of a queue given accepted push and pop
  function automatic int unsigned level_step(int unsigned cur, bit up, bit dn);
    if (up && !dn) return cur + 1;
    if (dn && !up) return cur - 1;
    return cur;
  endfunction

endpackage

// File: rtl/uart_lb_tx.sv
module uart_lb_tx
  import uart_lb_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          wr_valid_i,
  output logic          wr_ready_o,
  output logic          txs_o
);
  localparam int OSW = $clog2(OSR);
  localparam int BCW = $clog2(DW);

  ser_state_e    state_q;
  logic [OSW-1:0] os_q;
  logic [BCW-1:0] bit_q;
  logic [DW-1:0]  sh_q;
  logic [DW-1:0]  hold_q;
  logic           hold_v_q;

  // named events
  logic wr_accept, frame_start, os_last;
  assign wr_accept   = wr_valid_i && !hold_v_q;
  assign frame_start = (state_q == ST_IDLE) && hold_v_q && tick_i;
  assign os_last     = (os_q == OSW'(OSR - 1));
  assign wr_ready_o  = !hold_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= '0;
      hold_v_q <= 1'b0;
    end else if (wr_accept) begin
      hold_q   <= wr_data_i;
      hold_v_q <= 1'b1;
    end else if (frame_start) begin
      hold_v_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      os_q    <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (frame_start) begin
          sh_q    <= hold_q;
          os_q    <= '0;
          state_q <= ST_START;
        end
        ST_START: if (tick_i) begin
          if (os_last) begin
            os_q    <= '0;
            bit_q   <= '0;
            state_q <= ST_DATA;
          end else os_q <= os_q + 1'b1;
        end
        ST_DATA: if (tick_i) begin
          if (os_last) begin
            os_q <= '0;
            sh_q <= {1'b0, sh_q[DW-1:1]};
            if (bit_q == BCW'(DW - 1)) state_q <= ST_STOP;
            else bit_q <= bit_q + 1'b1;
          end else os_q <= os_q + 1'b1;
        end
        ST_STOP: if (tick_i) begin
          if (os_last) begin
            os_q    <= '0;
            state_q <= ST_IDLE;
          end else os_q <= os_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: txs_o = 1'b0;
      ST_DATA:  txs_o = sh_q[0];
      default:  txs_o = 1'b1;
    endcase
  end

  // a frame is only entered from idle, i.e. after the previous stop bit
  assert_start_after_stop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && $past(state_q) != ST_START) |-> $past(state_q) == ST_IDLE);

  assert_hold_kept_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_v_q && !frame_start) |=> hold_v_q);

endmodule

// File: rtl/uart_lb_rx.sv
module uart_lb_rx
  import uart_lb_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic          rxs_i,
  output logic          push_o,
  output logic [DW-1:0] data_o,
  output logic          stop_bad_o
);
  localparam int OSW = $clog2(OSR);
  localparam int BCW = $clog2(DW);
  localparam int HALF = OSR / 2;

  ser_state_e     state_q;
  logic [OSW-1:0] os_q;
  logic [BCW-1:0] bit_q;
  logic [DW-1:0]  sh_q;

  logic start_seen, mid_check, os_last, glitch;
  assign start_seen = (state_q == ST_IDLE) && en_i && tick_i && !rxs_i;
  assign mid_check  = (state_q == ST_START) && tick_i && (os_q == OSW'(HALF - 1));
  assign glitch     = mid_check && rxs_i;
  assign os_last    = (os_q == OSW'(OSR - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      os_q    <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
      os_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_seen) begin
          os_q    <= '0;
          state_q <= ST_START;
        end
        ST_START: if (tick_i) begin
          if (mid_check) begin
            os_q    <= '0;
            bit_q   <= '0;
            state_q <= glitch ? ST_IDLE : ST_DATA;
          end else os_q <= os_q + 1'b1;
        end
        ST_DATA: if (tick_i) begin
          if (os_last) begin
            os_q <= '0;
            sh_q <= {rxs_i, sh_q[DW-1:1]};
            if (bit_q == BCW'(DW - 1)) state_q <= ST_STOP;
            else bit_q <= bit_q + 1'b1;
          end else os_q <= os_q + 1'b1;
        end
        ST_STOP: if (tick_i) begin
          if (os_last) begin
            os_q    <= '0;
            state_q <= ST_IDLE;
          end else os_q <= os_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign push_o     = (state_q == ST_STOP) && tick_i && os_last && en_i;
  assign stop_bad_o = push_o && !rxs_i;
  assign data_o     = sh_q;

  assert_off_stays_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == ST_IDLE));

  assert_glitch_rejected_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glitch && en_i) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/uart_lb_fifo.sv
module uart_lb_fifo
  import uart_lb_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       flush_i,
  input  logic                       push_i,
  input  logic [DW-1:0]              wdata_i,
  input  logic                       err_i,
  input  logic                       pop_i,
  output logic [DW-1:0]              rdata_o,
  output logic                       empty_o,
  output logic [$clog2(DEPTH+1)-1:0] level_o,
  output logic                       ferr_o,
  output logic                       ovf_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [LW-1:0] count_q;
  logic          ferr_q, ovf_q;

  logic full, push_ok, pop_ok, drop;
  assign full    = (count_q == LW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign push_ok = push_i && !full;
  assign pop_ok  = pop_i && !empty_o;
  assign drop    = push_i && full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
      ferr_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (flush_i) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
      ferr_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (push_ok) wptr_q <= (wptr_q == PW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (pop_ok)  rptr_q <= (rptr_q == PW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      count_q <= LW'(level_step(32'(count_q), push_ok, pop_ok));
      if (drop)  ovf_q  <= 1'b1;
      if (err_i) ferr_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok && !flush_i) mem_q[wptr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rptr_q];
  assign level_o = count_q;
  assign ferr_o  = ferr_q;
  assign ovf_o   = ovf_q;

  assert_level_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= LW'(DEPTH));

  assert_flush_empties_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_q == '0 && !ovf_q && !ferr_q));

  assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && push_i && !pop_i && !flush_i) |=> (count_q == LW'(DEPTH) && ovf_q));

  assert_ferr_with_push_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ferr_q) |-> $past(push_i));

endmodule

// File: rtl/uart_lb_top.sv
module uart_lb_top
  import uart_lb_pkg::*;
#(
  parameter int DW    = 8,
  parameter int OSR   = 16,
  parameter int DIV   = 4,
  parameter int DEPTH = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sys_loop_i,
  input  logic                       line_loop_i,
  input  logic                       rx_en_i,
  input  logic                       flush_i,
  input  logic [DW-1:0]              tx_data_i,
  input  logic                       tx_valid_i,
  output logic                       tx_ready_o,
  output logic [DW-1:0]              rx_data_o,
  output logic                       rx_valid_o,
  input  logic                       rx_pop_i,
  output logic [$clog2(DEPTH+1)-1:0] rx_level_o,
  output logic                       frame_err_o,
  output logic                       overflow_o,
  input  logic                       rxd_i,
  output logic                       txd_o
);
  localparam int DCW = $clog2(DIV);

  // sample tick generator
  logic [DCW-1:0] div_q;
  logic           tick;
  assign tick = (div_q == DCW'(DIV - 1));
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end

  logic txs;
  uart_lb_tx #(.DW(DW), .OSR(OSR)) u_tx (
    .clk_i, .rst_ni, .tick_i(tick),
    .wr_data_i(tx_data_i), .wr_valid_i(tx_valid_i), .wr_ready_o(tx_ready_o),
    .txs_o(txs)
  );

  // receive source select, then two-stage synchronizer
  logic       rx_src, rx_s;
  logic [1:0] sync_q;
  assign rx_src = sys_loop_i ? txs : rxd_i;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rx_src};
  end
  assign rx_s = sync_q[1];

  logic          rx_push, rx_bad;
  logic [DW-1:0] rx_byte;
  uart_lb_rx #(.DW(DW), .OSR(OSR)) u_rx (
    .clk_i, .rst_ni, .tick_i(tick), .en_i(rx_en_i), .rxs_i(rx_s),
    .push_o(rx_push), .data_o(rx_byte), .stop_bad_o(rx_bad)
  );

  logic rx_empty;
  uart_lb_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .flush_i,
    .push_i(rx_push), .wdata_i(rx_byte), .err_i(rx_bad),
    .pop_i(rx_pop_i), .rdata_o(rx_data_o), .empty_o(rx_empty),
    .level_o(rx_level_o), .ferr_o(frame_err_o), .ovf_o(overflow_o)
  );
  assign rx_valid_o = !rx_empty;

  assign txd_o = line_loop_i ? rxd_i : txs;

  assert_sys_loop_path_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sys_loop_i, 2) |-> (rx_s == $past(txs, 2)));

endmodule

// File: tb/sim_uart_lb_top.sv
module sim_uart_lb_top;
  localparam int DW = 8, OSR = 16, DIV = 4, DEPTH = 8;
  localparam int BIT = OSR * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sys_loop = 1'b0, line_loop = 1'b0, rx_en = 1'b0, flush = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0, rx_pop = 1'b0, rxd = 1'b1;
  logic tx_ready, rx_valid, frame_err, overflow, txd;
  logic [7:0] rx_data;
  logic [3:0] rx_level;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  uart_lb_top #(.DW(DW), .OSR(OSR), .DIV(DIV), .DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sys_loop_i(sys_loop), .line_loop_i(line_loop),
    .rx_en_i(rx_en), .flush_i(flush), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .rx_pop_i(rx_pop), .rx_level_o(rx_level), .frame_err_o(frame_err),
    .overflow_o(overflow), .rxd_i(rxd), .txd_o(txd)
  );

  // {stimulus byte, expected received byte}
  localparam logic [15:0] VEC [8] = '{
    16'h5353, 16'h4D4D, 16'h0000, 16'hFFFF,
    16'hA5A5, 16'h8080, 16'h0101, 16'h3C3C
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_byte(input logic [7:0] b);
    while (!tx_ready) @(negedge clk);
    tx_data  = b;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pop_one();
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    @(negedge clk);
  endtask

  // drive a frame on rxd; a bad stop bit is held low for 3/4 of a bit
  task automatic send_line(input logic [7:0] b, input logic good_stop);
    rxd = 1'b0;
    wait_cyc(BIT);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      wait_cyc(BIT);
    end
    if (good_stop) begin
      rxd = 1'b1;
      wait_cyc(BIT);
    end else begin
      rxd = 1'b0;
      wait_cyc(BIT * 3 / 4);
      rxd = 1'b1;
      wait_cyc(BIT / 4);
    end
    wait_cyc(BIT);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(2);

    // R12 / R3: reset state
    chk("R3 level after reset", 32'(rx_level), 0);
    chk("R12 txd idle", 32'(txd), 1);
    chk("R12 tx_ready", 32'(tx_ready), 1);
    chk("R12 rx_valid", 32'(rx_valid), 0);
    chk("R12 frame_err", 32'(frame_err), 0);
    chk("R12 overflow", 32'(overflow), 0);

    // R1 / R6 / R8: table walked through system loopback, external pin held low
    sys_loop = 1'b1;
    rx_en    = 1'b1;
    wait_cyc(4);
    rxd = 1'b0;
    for (int k = 0; k < 8; k++) begin
      put_byte(VEC[k][15:8]);
      wait_cyc(11 * BIT);
      chk("R1 level after loopback byte", 32'(rx_level), 1);
      chk("R6 loopback data", 32'(rx_data), 32'(VEC[k][7:0]));
      pop_one();
    end
    chk("R1 no stray bytes from low pin", 32'(rx_level), 0);
    chk("R9 no frame error in loopback", 32'(frame_err), 0);

    // R11: back to back writes
    put_byte(8'h53);
    put_byte(8'hC7);
    wait_cyc(2);
    chk("R11 ready low while holding", 32'(tx_ready), 0);
    wait_cyc(23 * BIT);
    chk("R11 two bytes arrived", 32'(rx_level), 2);
    chk("R11 first byte", 32'(rx_data), 32'h53);
    pop_one();
    chk("R11 second byte", 32'(rx_data), 32'hC7);
    pop_one();

    // R6: LSB first on the pin
    rx_en = 1'b0;
    sys_loop = 1'b0;
    rxd = 1'b1;
    wait_cyc(4);
    put_byte(8'h01);
    for (int g = 0; g < 4 * BIT && txd; g++) @(negedge clk);
    wait_cyc(BIT / 2);
    chk("R6 start bit low", 32'(txd), 0);
    wait_cyc(BIT);
    chk("R6 bit0 first", 32'(txd), 1);
    wait_cyc(BIT);
    chk("R6 bit1 second", 32'(txd), 0);
    wait_cyc(9 * BIT);

    // R2: line loopback echoes rxd while the serializer runs
    line_loop = 1'b1;
    rxd = 1'b0;
    @(negedge clk);
    chk("R2 echo low", 32'(txd), 0);
    rxd = 1'b1;
    @(negedge clk);
    chk("R2 echo high", 32'(txd), 1);
    put_byte(8'h00);
    wait_cyc(2 * BIT);
    chk("R2 serializer hidden", 32'(txd), 1);
    rxd = 1'b0;
    @(negedge clk);
    chk("R2 echo during frame", 32'(txd), 0);
    rxd = 1'b1;
    wait_cyc(10 * BIT);
    line_loop = 1'b0;

    // R5: disabled receiver ignores a frame; enabled with idle pin stays empty
    send_line(8'h55, 1'b1);
    chk("R5 disabled no byte", 32'(rx_level), 0);
    rx_en = 1'b1;
    wait_cyc(20 * BIT);
    chk("R5 high pin no byte", 32'(rx_level), 0);

    // R4: short glitch rejected
    rxd = 1'b0;
    wait_cyc(16);
    rxd = 1'b1;
    wait_cyc(12 * BIT);
    chk("R4 glitch no byte", 32'(rx_level), 0);

    // R4 / R9: line held low gives a phantom 0x00 with frame error
    rxd = 1'b0;
    wait_cyc(630);
    rxd = 1'b1;
    wait_cyc(2 * BIT);
    chk("R4 phantom byte", 32'(rx_level), 1);
    chk("R4 phantom value", 32'(rx_data), 0);
    chk("R9 phantom frame error", 32'(frame_err), 1);

    // R7: flush
    do_flush();
    chk("R7 flush level", 32'(rx_level), 0);
    chk("R7 flush frame_err", 32'(frame_err), 0);

    // R9: real byte with bad stop still stored
    send_line(8'hA5, 1'b0);
    chk("R9 byte stored", 32'(rx_level), 1);
    chk("R9 byte value", 32'(rx_data), 32'hA5);
    chk("R9 frame error set", 32'(frame_err), 1);
    do_flush();

    // R10 / R8 / R3: overflow
    for (int n = 0; n < 9; n++) send_line(8'(8'h10 + n), 1'b1);
    chk("R3 level caps at depth", 32'(rx_level), 8);
    chk("R10 overflow set", 32'(overflow), 1);
    for (int n = 0; n < 8; n++) begin
      chk("R8 fifo order", 32'(rx_data), 32'(8'h10 + n));
      pop_one();
    end
    chk("R8 drained", 32'(rx_valid), 0);
    chk("R10 overflow sticky", 32'(overflow), 1);
    do_flush();
    chk("R7 flush clears overflow", 32'(overflow), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule